// File: doc/BRIEF.md
# Pipelined SAR Conversion Controller for a Serial Read Path

This block is the digital control for a successive-approximation converter. It sits behind the read path of a two-wire serial slave. Each time the bus side signals a read trigger, the controller samples one input channel and starts a new conversion. A trigger is either the end of the acknowledge after a read address, or a master acknowledge after a data byte. At the moment the conversion starts, the result of the previous conversion is latched into the byte the slave shifts out. The readout therefore always runs exactly one conversion behind the sampling. After reset the first byte handed out is the mid-scale code 0x80.

The search borrows a DAC that is otherwise driven with a user output code. The comparator, the DAC and the sample-and-hold are outside the block and appear as plain ports. A channel pointer selects the input. It can be loaded directly, and it can step to the next channel after every finished conversion, wrapping after the last one. A differential flag makes the stored result two's complement instead of straight binary.

Top module: `sar_readout_ctrl`

## Requirements
- R1: After reset, `tx_byte` is 0x80, `busy` is 0 and `ch_ptr` is 0.
- R2: A one-cycle `trig` pulse that is not cancelled raises `busy` on the second rising edge after the pulse. `busy` then stays high for exactly 8 cycles.
- R3: On the edge where a conversion starts, `tx_byte` takes the result of the previous completed conversion, or 0x80 if there was none. It holds that value until the next conversion starts.
- R4: The search drives `dac_code` with trial 0x80 in its first busy cycle. `cmp_hi` = 1 means the sample is at or above the trial code. Bits are decided from MSB to LSB, so that in single-ended mode the stored result equals the sampled 8-bit level.
- R5: When `diff_mode` is 1 at conversion start, the stored result is the search value with bit 7 inverted, giving two's complement.
- R6: When `auto_inc` is 1 as a conversion completes, `ch_ptr` advances by one and wraps from NCH-1 to 0. When `auto_inc` is 0, `ch_ptr` is unchanged.
- R7: A `bus_stop` pulse cancels a pending trigger, whether it comes in the same cycle as `trig` or in the cycle after it. No conversion runs, and `tx_byte` and `ch_ptr` are left unchanged.
- R8: While `busy` is 0, `dac_code` equals `user_dac`.
- R9: `smp_ch` equals `ch_ptr` at conversion start and is held stable for the whole conversion.
- R10: A `ch_load` pulse sets `ch_ptr` to `ch_sel`. Values of NCH or more load 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig | input | 1 | Read trigger pulse (end of an acknowledge clock in a read) |
| bus_stop | input | 1 | Stop condition or missing acknowledge; cancels a pending trigger |
| auto_inc | input | 1 | Step the channel after each conversion |
| diff_mode | input | 1 | Differential coding for the next conversion |
| ch_load | input | 1 | Load the channel pointer |
| ch_sel | input | CW | Channel value to load |
| user_dac | input | DW | DAC code used outside conversions |
| cmp_hi | input | 1 | Comparator: sample at or above `dac_code` |
| busy | output | 1 | SAR cycle in progress, DAC taken |
| dac_code | output | DW | Code to the DAC |
| smp_ch | output | CW | Channel held for the running conversion |
| ch_ptr | output | CW | Current channel pointer |
| tx_byte | output | DW | Byte handed to the serial shifter |

## Verification
The bench builds the block with NCH = 3 and DW = 8. Three channels is not a power of two, so the pointer must wrap back to 0 explicitly from channel 2, and a load value of 3 falls in the out-of-range case. An 8-bit width lets the bench model the comparator from a per-channel level and check every result exactly, including the two's-complement extremes 0x80 and 0x7F. Random reads mix cancellations in both cancel slots with modes and levels that change from read to read.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic {
        SAR_IDLE = 1'b0,
        SAR_CMP  = 1'b1
    } sar_state_e;
endpackage

// File: rtl/sar_trigger.sv
module sar_trigger (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    input  logic bus_stop,
    input  logic eng_idle,
    output logic start
);
    typedef struct packed {
        logic pend;
    } trg_s;

    trg_s s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = s_q.pend & ~bus_stop & eng_idle;
        if (start)    s_d.pend = 1'b0;
        if (trig)     s_d.pend = 1'b1;
        if (bus_stop) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: a stop leaves nothing to start on the following cycle
    p_stop_cancels_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !start);
endmodule

// File: rtl/sar_engine.sv
module sar_engine import sar_pkg::*; #(
    parameter int DW = 8,
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          diff_mode,
    input  logic [CW-1:0] ch_in,
    input  logic          cmp_hi,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] trial,
    output logic [CW-1:0] hold_ch,
    output logic [DW-1:0] result
);
    localparam logic [DW-1:0] MSB = DW'(1) << (DW - 1);

    typedef struct packed {
        sar_state_e    st;
        logic [DW-1:0] trial;
        logic [DW-1:0] mask;
        logic          diff;
        logic [CW-1:0] ch;
        logic [DW-1:0] res;
    } eng_s;

    eng_s s_d, s_q;
    logic [DW-1:0] kept;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        kept = cmp_hi ? s_q.trial : (s_q.trial & ~s_q.mask);
        unique case (s_q.st)
            SAR_IDLE: begin
                if (start) begin
                    s_d.st    = SAR_CMP;
                    s_d.trial = MSB;
                    s_d.mask  = MSB;
                    s_d.diff  = diff_mode;
                    s_d.ch    = ch_in;
                end
            end
            SAR_CMP: begin
                if (s_q.mask[0]) begin
                    done      = 1'b1;
                    s_d.st    = SAR_IDLE;
                    s_d.res   = s_q.diff ? (kept ^ MSB) : kept;
                    s_d.mask  = '0;
                end else begin
                    s_d.mask  = s_q.mask >> 1;
                    s_d.trial = kept | (s_q.mask >> 1);
                end
            end
            default: s_d.st = SAR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.st    <= SAR_IDLE;
            s_q.res   <= MSB;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.st == SAR_CMP);
    assign trial   = s_q.trial;
    assign hold_ch = s_q.ch;
    assign result  = s_q.res;

    // R2: an accepted start puts the engine into its search
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R4: exactly one bit under test during the search
    p_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $countones(s_q.mask) == 1);
    // R9: the held channel does not move within a conversion
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(s_q.ch));
    // R3: the stored result only changes when a search finishes
    p_res_on_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(done) |-> $stable(s_q.res));
endmodule

// File: rtl/sar_chan_ptr.sv
module sar_chan_ptr #(
    parameter int NCH = 4,
    parameter int CW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ch_load,
    input  logic [CW-1:0] ch_sel,
    input  logic          advance,
    output logic [CW-1:0] ptr
);
    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    typedef struct packed {
        logic [CW-1:0] ptr;
    } ptr_s;

    ptr_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ch_load) begin
            s_d.ptr = (ch_sel > LAST) ? '0 : ch_sel;
        end else if (advance) begin
            s_d.ptr = (s_q.ptr == LAST) ? '0 : s_q.ptr + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ptr = s_q.ptr;

    // R6: the pointer never leaves the channel range
    p_ptr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.ptr <= LAST);
    // R6: without load or step the pointer holds
    p_ptr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_load && !advance) |=> $stable(s_q.ptr));
endmodule

// File: rtl/sar_readout_ctrl.sv
module sar_readout_ctrl #(
    parameter  int NCH = 4,
    parameter  int DW  = 8,
    localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig,
    input  logic          bus_stop,
    input  logic          auto_inc,
    input  logic          diff_mode,
    input  logic          ch_load,
    input  logic [CW-1:0] ch_sel,
    input  logic [DW-1:0] user_dac,
    input  logic          cmp_hi,
    output logic          busy,
    output logic [DW-1:0] dac_code,
    output logic [CW-1:0] smp_ch,
    output logic [CW-1:0] ch_ptr,
    output logic [DW-1:0] tx_byte
);
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    typedef struct packed {
        logic [DW-1:0] tx;
    } top_s;

    top_s          s_d, s_q;
    logic          start;
    logic          done;
    logic [DW-1:0] trial;
    logic [DW-1:0] result;

    sar_trigger u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .bus_stop (bus_stop),
        .eng_idle (~busy),
        .start    (start)
    );

    sar_engine #(.DW(DW), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .diff_mode (diff_mode),
        .ch_in     (ch_ptr),
        .cmp_hi    (cmp_hi),
        .busy      (busy),
        .done      (done),
        .trial     (trial),
        .hold_ch   (smp_ch),
        .result    (result)
    );

    sar_chan_ptr #(.NCH(NCH), .CW(CW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ch_load (ch_load),
        .ch_sel  (ch_sel),
        .advance (done & auto_inc),
        .ptr     (ch_ptr)
    );

    always_comb begin
        s_d = s_q;
        if (start) s_d.tx = result;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.tx <= MID;
        else        s_q    <= s_d;
    end

    assign tx_byte  = s_q.tx;
    assign dac_code = busy ? trial : user_dac;

    // R3: the byte handed out is the result stored before this start
    p_one_behind_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> tx_byte == $past(result));
    // R9: the held channel is the pointer value at start
    p_hold_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> smp_ch == $past(ch_ptr));
    // R4: the search opens with the mid-scale trial
    p_first_trial_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> dac_code == MID);
endmodule

// File: tb/sar_readout_ctrl_bench.sv
`timescale 1ns/1ps
module sar_readout_ctrl_bench;
    localparam int NCH = 3;
    localparam int DW  = 8;
    localparam int CW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig = 1'b0, bus_stop = 1'b0, auto_inc = 1'b0, diff_mode = 1'b0;
    logic          ch_load = 1'b0;
    logic [CW-1:0] ch_sel = '0;
    logic [DW-1:0] user_dac = 8'h5A;
    logic          cmp_hi;
    logic          busy;
    logic [DW-1:0] dac_code;
    logic [CW-1:0] smp_ch, ch_ptr;
    logic [DW-1:0] tx_byte;

    logic [DW-1:0] vin [NCH];
    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [DW-1:0] exp_res = 8'h80;
    logic [DW-1:0] exp_tx  = 8'h80;
    int            exp_ptr = 0;

    always #2.5 clk = ~clk;

    assign cmp_hi = (vin[smp_ch] >= dac_code);

    sar_readout_ctrl #(.NCH(NCH), .DW(DW)) u_sar_readout_ctrl (
        .clk(clk), .rst_n(rst_n), .trig(trig), .bus_stop(bus_stop),
        .auto_inc(auto_inc), .diff_mode(diff_mode), .ch_load(ch_load),
        .ch_sel(ch_sel), .user_dac(user_dac), .cmp_hi(cmp_hi), .busy(busy),
        .dac_code(dac_code), .smp_ch(smp_ch), .ch_ptr(ch_ptr), .tx_byte(tx_byte)
    );

    function automatic logic [DW-1:0] conv(logic [DW-1:0] v, logic d);
        return d ? (v ^ 8'h80) : v;
    endfunction

    function automatic int next_ptr(int p);
        return (p == NCH - 1) ? 0 : p + 1;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_ch(int c);
        @(negedge clk); ch_load = 1'b1; ch_sel = CW'(c);
        @(negedge clk); ch_load = 1'b0;
        exp_ptr = (c >= NCH) ? 0 : c;
        check("R10 ch_ptr", ch_ptr, exp_ptr);
    endtask

    // ab: 0 normal, 1 stop with trigger, 2 stop one cycle later
    task automatic do_read(int ab);
        @(negedge clk); trig = 1'b1; bus_stop = (ab == 1);
        @(negedge clk); trig = 1'b0; bus_stop = (ab == 2);
        @(negedge clk); bus_stop = 1'b0;
        if (ab == 0) begin
            check("R2 busy raised", busy, 1);
            check("R4 first trial", dac_code, 8'h80);
            check("R9 held channel", smp_ch, exp_ptr);
            exp_tx = exp_res;
            exp_res = conv(vin[exp_ptr], diff_mode);
            repeat (7) @(negedge clk);
            check("R2 busy still high", busy, 1);
            @(negedge clk);
            check("R2 busy low after 8", busy, 0);
            if (auto_inc) exp_ptr = next_ptr(exp_ptr);
        end else begin
            check("R7 no conversion", busy, 0);
            repeat (8) @(negedge clk);
        end
        check("R3 tx_byte", tx_byte, exp_tx);
        check("R6 ch_ptr", ch_ptr, exp_ptr);
        check("R8 dac idle", dac_code, user_dac);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) vin[i] = DW'(8'h11 * (i + 1));
        repeat (3) @(negedge clk);
        check("R1 tx_byte", tx_byte, 8'h80);
        check("R1 busy", busy, 0);
        check("R1 ch_ptr", ch_ptr, 0);
        rst_n = 1'b1;

        // first read hands out the reset code
        vin[0] = 8'hC3;
        do_read(0);
        // one-behind: previous C3 comes out now (R3, R4)
        vin[0] = 8'h00;
        do_read(0);
        // differential extremes (R5)
        diff_mode = 1'b1;
        do_read(0);                         // 0x00 -> 0x80 stored
        vin[0] = 8'hFF;
        do_read(0);                         // 0xFF -> 0x7F stored
        diff_mode = 1'b0;
        do_read(0);
        check("R5 diff 0xFF", tx_byte, 8'h7F);
        // auto increment wraps 2 -> 0 (R6)
        auto_inc = 1'b1;
        load_ch(1);
        do_read(0);
        do_read(0);
        check("R6 wrapped", ch_ptr, 0);
        // out of range load (R10)
        load_ch(3);
        // cancellations (R7)
        do_read(1);
        do_read(2);
        // pointer fixed without auto increment (R6)
        auto_inc = 1'b0;
        load_ch(2);
        do_read(0);

        void'($urandom(32'd1234));
        for (int n = 0; n < 40; n++) begin
            for (int i = 0; i < NCH; i++) vin[i] = DW'($urandom);
            diff_mode = 1'($urandom);
            auto_inc  = 1'($urandom);
            user_dac  = DW'($urandom);
            if ($urandom_range(0, 7) == 0) load_ch($urandom_range(0, 3));
            do_read(($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 2)) : 0);
        end

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule